// File: doc/BRIEF.md
# Block-Security Lookup Table Configurator

This block is the register side of a memory security filter. Memory is split into blocks of a fixed power-of-two size. Each block has one bit that says whether it belongs to the secure world (0) or the non-secure world (1). The bits are packed 32 to a table word. Software programs the table through a 32-bit register slave. It points an index register at a table word and then reads or writes that word through a data window. With auto-increment on, a run of full-word accesses steps through the table, and the index wraps back to word 0 after the last word.

The filtering logic reads three things from this block: the whole table, the blocked-access response mode and the lockdown state. Once software sets the lockdown bit, the control register, the table and the interrupt-enable bit are frozen until the next reset.

Register accesses use a single-cycle request: valid, write, byte address, byte strobes and a secure flag. Read data appears on the cycle after the request. A request marked non-secure that targets an offset below 0xFD0 reads zero and changes nothing. The request port has no response signal, so such an access still completes as normal (OK).

Top module: `blkcfg_regs`

## Requirements
- R1: After reset, the control register reads 0x00000100 (auto-increment on, lockdown off), the index reads 0, every table word is 0, and interrupt enable (offset 0x28, bit 0) reads 1.
- R2: The control register at offset 0x00 keeps only three bits: bit 4 (response mode), bit 8 (auto-increment) and bit 31 (lockdown). All other bits read zero. Bit 4 drives `err_resp` and bit 31 drives `lockdown`.
- R3: The data window at offset 0x1C reads and writes the table word selected by the index. Table word k appears on `lut_bits[32k+31:32k]`. A full-word access (strobe 4'hF) with auto-increment on advances the index by one, modulo the number of table words.
- R4: A window access with any strobe other than 4'hF never changes the index.
- R5: A write to the index register (offset 0x18) stores the written value modulo the number of table words, so the index is always below that number.
- R6: Offset 0x10 reads the number of table words minus one. Offset 0x14 reads log2(block size in bytes) minus 5.
- R7: While lockdown is set, writes to the control register, the window and interrupt enable have no effect, and an ignored window write does not advance the index. Index writes still take effect. Only reset clears lockdown.
- R8: A request with the secure flag low and an offset below 0xFD0 returns read data 0 and changes no state.
- R9: A write with a partial strobe merges the strobed byte lanes into the current value of the control register, the index register or the selected table word. For interrupt enable, the unstrobed lanes are taken as zero.
- R10: Read data is registered and appears one cycle after the request. Byte lanes that are not strobed read zero, and the strobed lanes keep their positions. Unmapped offsets read zero.
- R11: Interrupt enable is a single bit at offset 0x28, bit 0. It drives `int_enable`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the register space |
| req_strb | input | 4 | Byte-lane strobes, one per lane, little-endian |
| req_wdata | input | 32 | Write data, lanes in place |
| req_secure | input | 1 | Request comes from the secure world |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| lut_bits | output | WORDS*32 | Whole table, word k at bits 32k+31:32k |
| err_resp | output | 1 | Blocked accesses get a bus error (1) or read-zero/write-ignore (0) |
| lockdown | output | 1 | Configuration is frozen |
| int_enable | output | 1 | Interrupt enable bit |

## Verification
The assertions assume that the request fields are stable and known whenever `req_valid` is high. They also assume that at most one request arrives per cycle. The properties about stable state assume that reset is not applied in the middle of a window.

The stimulus drives every request on the falling edge and holds it for exactly one cycle. It uses strobe patterns that are contiguous lanes or a full word. It only applies reset between requests, with `req_valid` low.

// File: rtl/blkcfg_pkg.sv
package blkcfg_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_MAX,
    SEL_CFG,
    SEL_IDX,
    SEL_LUT,
    SEL_INTEN
  } reg_sel_e;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_MAX   = 12'h010;
  localparam logic [11:0] OFS_CFG   = 12'h014;
  localparam logic [11:0] OFS_IDX   = 12'h018;
  localparam logic [11:0] OFS_LUT   = 12'h01C;
  localparam logic [11:0] OFS_INTEN = 12'h028;
  localparam logic [11:0] NS_LIMIT  = 12'hFD0;

  localparam logic [31:0] CTRL_KEEP  = 32'h8000_0110;
  localparam logic [31:0] CTRL_RESET = 32'h0000_0100;
  localparam int          BIT_RESP   = 4;
  localparam int          BIT_AINC   = 8;
  localparam int          BIT_LOCK   = 31;

  // Expand byte strobes into a 32-bit bit mask.
  function automatic logic [31:0] lane_mask(input logic [3:0] strb);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{strb[i]}};
    return m;
  endfunction

  // Put the strobed lanes of the new value over the old value.
  function automatic logic [31:0] merge_lanes(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  strb);
    logic [31:0] m;
    m = lane_mask(strb);
    return (old_v & ~m) | (new_v & m);
  endfunction

  // Reduce a written index value into the table range.
  function automatic logic [31:0] wrap_index(input logic [31:0] v,
                                             input int unsigned words);
    return v % words;
  endfunction

  // Index after one auto-increment step.
  function automatic logic [31:0] next_index(input logic [31:0] i,
                                             input int unsigned words);
    return (i + 32'd1 >= words) ? 32'd0 : i + 32'd1;
  endfunction

endpackage

// File: rtl/blkcfg_decode.sv
module blkcfg_decode
  import blkcfg_pkg::*;
(
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [3:0]  req_strb,
  input  logic        req_secure,
  output reg_sel_e    sel,
  output logic        rd_en,
  output logic        wr_en,
  output logic        full_word,
  output logic        ns_blocked
);

  logic [11:0] offset;
  logic        open;

  assign offset     = {req_addr[11:2], 2'b00};
  assign ns_blocked = req_valid && !req_secure && (offset < NS_LIMIT);
  assign open       = req_valid && !ns_blocked;
  assign rd_en      = open && !req_write;
  assign wr_en      = open && req_write;
  assign full_word  = (req_strb == 4'hF);

  always_comb begin
    case (offset)
      OFS_CTRL:  sel = SEL_CTRL;
      OFS_MAX:   sel = SEL_MAX;
      OFS_CFG:   sel = SEL_CFG;
      OFS_IDX:   sel = SEL_IDX;
      OFS_LUT:   sel = SEL_LUT;
      OFS_INTEN: sel = SEL_INTEN;
      default:   sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/blkcfg_ctrl.sv
module blkcfg_ctrl
  import blkcfg_pkg::*;
#(
  parameter int WORDS = 7,
  parameter int IDXW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  reg_sel_e        sel,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic            full_word,
  input  logic [3:0]      strb,
  input  logic [31:0]     wdata,
  output logic [31:0]     ctrl_q,
  output logic [IDXW-1:0] idx_q,
  output logic            inten_q,
  output logic            lut_we,
  output logic            idx_step
);

  logic            locked;
  logic            ctrl_wr;
  logic            idx_wr;
  logic            inten_wr;
  logic [31:0]     ctrl_d;
  logic [IDXW-1:0] idx_d;
  logic [IDXW-1:0] idx_inc;
  logic            inten_d;

  assign locked   = ctrl_q[BIT_LOCK];
  assign ctrl_wr  = wr_en && (sel == SEL_CTRL) && !locked;
  assign idx_wr   = wr_en && (sel == SEL_IDX);
  assign inten_wr = wr_en && (sel == SEL_INTEN) && !locked;
  assign lut_we   = wr_en && (sel == SEL_LUT) && !locked;
  assign idx_step = (sel == SEL_LUT) && full_word && ctrl_q[BIT_AINC] &&
                    (rd_en || lut_we);

  assign ctrl_d  = merge_lanes(ctrl_q, wdata, strb) & CTRL_KEEP;
  assign idx_d   = IDXW'(wrap_index(merge_lanes(32'(idx_q), wdata, strb), WORDS));
  assign idx_inc = IDXW'(next_index(32'(idx_q), WORDS));
  assign inten_d = ((wdata & lane_mask(strb) & 32'h1) != 32'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      idx_q   <= '0;
      inten_q <= 1'b1;
    end else begin
      if (ctrl_wr)  ctrl_q  <= ctrl_d;
      if (inten_wr) inten_q <= inten_d;
      if (idx_wr)        idx_q <= idx_d;
      else if (idx_step) idx_q <= idx_inc;
    end
  end

endmodule

// File: rtl/blkcfg_table.sv
module blkcfg_table
  import blkcfg_pkg::*;
#(
  parameter int WORDS = 7,
  parameter int IDXW  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDXW-1:0]    idx,
  input  logic [3:0]         strb,
  input  logic [31:0]        wdata,
  output logic [31:0]        rd_word,
  output logic [WORDS*32-1:0] flat
);

  logic [31:0] word_q [WORDS];

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic hit;
    assign hit = we && (idx == IDXW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[k] <= '0;
      else if (hit) word_q[k] <= merge_lanes(word_q[k], wdata, strb);
    end
    assign flat[k*32 +: 32] = word_q[k];
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < WORDS; k++)
      if (idx == IDXW'(k)) rd_word = word_q[k];
  end

endmodule

// File: rtl/blkcfg_regs.sv
module blkcfg_regs
  import blkcfg_pkg::*;
#(
  parameter int NUM_BLOCKS  = 200,
  parameter int BLOCK_BYTES = 4096,
  localparam int WORDS      = (NUM_BLOCKS + 31) / 32,
  localparam int IDXW       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [11:0]         req_addr,
  input  logic [3:0]          req_strb,
  input  logic [31:0]         req_wdata,
  input  logic                req_secure,
  output logic [31:0]         rsp_rdata,
  output logic [WORDS*32-1:0] lut_bits,
  output logic                err_resp,
  output logic                lockdown,
  output logic                int_enable
);

  localparam int CFG_VAL = $clog2(BLOCK_BYTES) - 5;

  reg_sel_e        sel;
  logic            rd_en;
  logic            wr_en;
  logic            full_word;
  logic            ns_blocked;
  logic [31:0]     ctrl_q;
  logic [IDXW-1:0] idx_q;
  logic            inten_q;
  logic            lut_we;
  logic            idx_step;
  logic [31:0]     lut_word;
  logic [31:0]     rd_mux;
  logic            unused_ns;

  blkcfg_decode u_decode (
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_strb   (req_strb),
    .req_secure (req_secure),
    .sel        (sel),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .full_word  (full_word),
    .ns_blocked (ns_blocked)
  );

  blkcfg_ctrl #(.WORDS(WORDS), .IDXW(IDXW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .full_word (full_word),
    .strb      (req_strb),
    .wdata     (req_wdata),
    .ctrl_q    (ctrl_q),
    .idx_q     (idx_q),
    .inten_q   (inten_q),
    .lut_we    (lut_we),
    .idx_step  (idx_step)
  );

  blkcfg_table #(.WORDS(WORDS), .IDXW(IDXW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (lut_we),
    .idx     (idx_q),
    .strb    (req_strb),
    .wdata   (req_wdata),
    .rd_word (lut_word),
    .flat    (lut_bits)
  );

  assign unused_ns = ns_blocked ^ idx_step;

  always_comb begin
    case (sel)
      SEL_CTRL:  rd_mux = ctrl_q;
      SEL_MAX:   rd_mux = 32'(WORDS - 1);
      SEL_CFG:   rd_mux = 32'(CFG_VAL);
      SEL_IDX:   rd_mux = 32'(idx_q);
      SEL_LUT:   rd_mux = lut_word;
      SEL_INTEN: rd_mux = {31'b0, inten_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rsp_rdata <= '0;
    else if (rd_en) rsp_rdata <= rd_mux & lane_mask(req_strb);
    else            rsp_rdata <= '0;
  end

  assign err_resp   = ctrl_q[BIT_RESP];
  assign lockdown   = ctrl_q[BIT_LOCK];
  assign int_enable = inten_q;

endmodule

// File: rtl/blkcfg_regs_chk.sv
module blkcfg_regs_chk #(
  parameter int WORDS = 7,
  parameter int IDXW  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [11:0]         req_addr,
  input logic [3:0]          req_strb,
  input logic                req_secure,
  input logic [31:0]         rsp_rdata,
  input logic [WORDS*32-1:0] lut_bits,
  input logic                err_resp,
  input logic                lockdown,
  input logic [IDXW-1:0]     idx_q
);

  logic ns_req;
  logic win_part;
  assign ns_req   = req_valid && !req_secure && (req_addr < 12'hFD0);
  assign win_part = req_valid && (req_addr[11:2] == 10'h007) && (req_strb != 4'hF);

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown |=> lockdown);

  // R7
  lock_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown |=> $stable(lut_bits));

  // R7
  lock_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown |=> $stable(err_resp));

  // R8
  ns_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_req && !req_write) |=> (rsp_rdata == 32'h0));

  // R8
  ns_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ns_req |=> ($stable(lut_bits) && $stable(idx_q)));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(idx_q) < WORDS));

  // R4
  part_noinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_part |=> $stable(idx_q));

  // R10
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_strb[0]) |=> (rsp_rdata[7:0] == 8'h00));

endmodule

bind blkcfg_regs blkcfg_regs_chk #(.WORDS(WORDS), .IDXW(IDXW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_strb   (req_strb),
  .req_secure (req_secure),
  .rsp_rdata  (rsp_rdata),
  .lut_bits   (lut_bits),
  .err_resp   (err_resp),
  .lockdown   (lockdown),
  .idx_q      (idx_q)
);

// File: tb/blkcfg_regs_bench.sv
`timescale 1ns/1ps
module blkcfg_regs_bench;

  localparam int WORDS = 7;      // 200 blocks / 32 rounded up
  localparam int NV    = 54;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [11:0]       req_addr = '0;
  logic [3:0]        req_strb = '0;
  logic [31:0]       req_wdata = '0;
  logic              req_secure = 1'b0;
  logic [31:0]       rsp_rdata;
  logic [WORDS*32-1:0] lut_bits;
  logic              err_resp;
  logic              lockdown;
  logic              int_enable;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  blkcfg_regs #(.NUM_BLOCKS(200), .BLOCK_BYTES(4096)) u_blkcfg_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_strb   (req_strb),
    .req_wdata  (req_wdata),
    .req_secure (req_secure),
    .rsp_rdata  (rsp_rdata),
    .lut_bits   (lut_bits),
    .err_resp   (err_resp),
    .lockdown   (lockdown),
    .int_enable (int_enable)
  );

  // {write, secure, addr, strb, wdata, expected, check}
  localparam logic [82:0] VEC [NV] = '{
    {1'b0,1'b1,12'h000,4'hF,32'h0,32'h0000_0100,1'b1}, // 0  R1 ctrl
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0000,1'b1}, // 1  R1 idx
    {1'b0,1'b1,12'h010,4'hF,32'h0,32'h0000_0006,1'b1}, // 2  R6 max
    {1'b0,1'b1,12'h014,4'hF,32'h0,32'h0000_0007,1'b1}, // 3  R6 cfg
    {1'b0,1'b1,12'h028,4'hF,32'h0,32'h0000_0001,1'b1}, // 4  R1 inten
    {1'b0,1'b1,12'h01C,4'hF,32'h0,32'h0000_0000,1'b1}, // 5  R1 table zero
    {1'b1,1'b1,12'h018,4'hF,32'h0,32'h0,1'b0},          // 6
    {1'b1,1'b1,12'h01C,4'hF,32'hA5A5_0001,32'h0,1'b0},  // 7
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0001,1'b1}, // 8  R3 inc
    {1'b1,1'b1,12'h01C,4'hF,32'h1111_2222,32'h0,1'b0},  // 9
    {1'b1,1'b1,12'h018,4'hF,32'h0,32'h0,1'b0},          // 10
    {1'b0,1'b1,12'h01C,4'hF,32'h0,32'hA5A5_0001,1'b1}, // 11 R3
    {1'b0,1'b1,12'h01C,4'hF,32'h0,32'h1111_2222,1'b1}, // 12 R3
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0002,1'b1}, // 13 R3
    {1'b1,1'b1,12'h018,4'hF,32'h0000_000D,32'h0,1'b0},  // 14
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0006,1'b1}, // 15 R5 13 mod 7
    {1'b1,1'b1,12'h01C,4'hF,32'hDEAD_BEEF,32'h0,1'b0},  // 16
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0000,1'b1}, // 17 R3 wrap
    {1'b1,1'b1,12'h018,4'h2,32'h0000_0300,32'h0,1'b0},  // 18
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0005,1'b1}, // 19 R9 768 mod 7
    {1'b1,1'b1,12'h018,4'hF,32'h0,32'h0,1'b0},          // 20
    {1'b1,1'b1,12'h01D,4'h2,32'h0000_7700,32'h0,1'b0},  // 21
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0000,1'b1}, // 22 R4
    {1'b0,1'b1,12'h01E,4'hC,32'h0,32'hA5A5_0000,1'b1}, // 23 R10
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0000,1'b1}, // 24 R4
    {1'b0,1'b1,12'h01C,4'h1,32'h0,32'h0000_0001,1'b1}, // 25 R10
    {1'b0,1'b0,12'h000,4'hF,32'h0,32'h0000_0000,1'b1}, // 26 R8
    {1'b1,1'b0,12'h018,4'hF,32'h0000_0003,32'h0,1'b0},  // 27
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0000,1'b1}, // 28 R8
    {1'b1,1'b0,12'h01C,4'hF,32'h0,32'h0,1'b0},          // 29
    {1'b0,1'b0,12'h01C,4'hF,32'h0,32'h0000_0000,1'b1}, // 30 R8
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0000,1'b1}, // 31 R8
    {1'b0,1'b1,12'h01C,4'hF,32'h0,32'hA5A5_7701,1'b1}, // 32 R9 merge
    {1'b1,1'b1,12'h000,4'hF,32'h0,32'h0,1'b0},          // 33
    {1'b1,1'b1,12'h018,4'hF,32'h0,32'h0,1'b0},          // 34
    {1'b0,1'b1,12'h01C,4'hF,32'h0,32'hA5A5_7701,1'b1}, // 35 R2
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0000,1'b1}, // 36 R2 no inc
    {1'b1,1'b1,12'h000,4'h1,32'hFFFF_FFFF,32'h0,1'b0},  // 37
    {1'b0,1'b1,12'h000,4'hF,32'h0,32'h0000_0010,1'b1}, // 38 R2
    {1'b1,1'b1,12'h029,4'h2,32'h0000_0100,32'h0,1'b0},  // 39
    {1'b0,1'b1,12'h028,4'hF,32'h0,32'h0000_0000,1'b1}, // 40 R9 zero fill
    {1'b1,1'b1,12'h028,4'hF,32'h0000_0001,32'h0,1'b0},  // 41
    {1'b0,1'b1,12'h028,4'hF,32'h0,32'h0000_0001,1'b1}, // 42 R11
    {1'b1,1'b1,12'h000,4'hF,32'h8000_0100,32'h0,1'b0},  // 43
    {1'b0,1'b1,12'h000,4'hF,32'h0,32'h8000_0100,1'b1}, // 44 R7
    {1'b1,1'b1,12'h01C,4'hF,32'h0,32'h0,1'b0},          // 45
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0000,1'b1}, // 46 R7
    {1'b0,1'b1,12'h01C,4'hF,32'h0,32'hA5A5_7701,1'b1}, // 47 R7
    {1'b1,1'b1,12'h000,4'hF,32'h0,32'h0,1'b0},          // 48
    {1'b0,1'b1,12'h000,4'hF,32'h0,32'h8000_0100,1'b1}, // 49 R7
    {1'b1,1'b1,12'h028,4'hF,32'h0,32'h0,1'b0},          // 50
    {1'b0,1'b1,12'h028,4'hF,32'h0,32'h0000_0001,1'b1}, // 51 R7
    {1'b1,1'b1,12'h018,4'hF,32'h0000_0004,32'h0,1'b0},  // 52
    {1'b0,1'b1,12'h018,4'hF,32'h0,32'h0000_0004,1'b1}  // 53 R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic sec, input logic [11:0] a,
                        input logic [3:0] s, input logic [31:0] d);
    req_valid  = 1'b1;
    req_write  = wr;
    req_secure = sec;
    req_addr   = a;
    req_strb   = s;
    req_wdata  = d;
    @(posedge clk);
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 lockdown", 32'(lockdown), 32'h0);
    check("R1 table", 32'(lut_bits != '0), 32'h0);
    check("R11 int_enable", 32'(int_enable), 32'h1);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][82], VEC[i][81], VEC[i][80:69], VEC[i][68:65], VEC[i][64:33]);
      if (VEC[i][0]) check($sformatf("vector %0d", i), rsp_rdata, VEC[i][32:1]);
    end

    // R7 frozen state at the ports, R3 word positions
    check("R7 lockdown port", 32'(lockdown), 32'h1);
    check("R2 err_resp port", 32'(err_resp), 32'h0);
    check("R11 int_enable port", 32'(int_enable), 32'h1);
    check("R3 word0", lut_bits[31:0], 32'hA5A5_7701);
    check("R3 word1", lut_bits[63:32], 32'h1111_2222);
    check("R3 word6", lut_bits[223:192], 32'hDEAD_BEEF);

    // R7 only reset clears lockdown; R1 values return
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 lock cleared", 32'(lockdown), 32'h0);
    check("R1 table cleared", 32'(lut_bits != '0), 32'h0);
    access(1'b0, 1'b1, 12'h000, 4'hF, 32'h0);
    check("R1 ctrl after reset", rsp_rdata, 32'h0000_0100);

    // R2 response mode bit drives err_resp
    access(1'b1, 1'b1, 12'h000, 4'hF, 32'h7FFF_FEFF);
    check("R2 err_resp set", 32'(err_resp), 32'h1);
    access(1'b0, 1'b1, 12'h000, 4'hF, 32'h0);
    check("R2 ctrl masked", rsp_rdata, 32'h0000_0010);

    // R10 unmapped offset reads zero
    access(1'b0, 1'b1, 12'h004, 4'hF, 32'h0);
    check("R10 unmapped", rsp_rdata, 32'h0);

    finish_run();
  end

endmodule